// File: doc/BRIEF.md
# Trap Entry and Delegation Controller

This block decides, in a single registered step, where a processor goes when an exception is raised or an interrupt is sampled at an instruction boundary. It receives the current privilege level, the interrupt-enable and previous-state status bits, the two delegation masks, both trap vector bases and the per-privilege breakpoint-to-debug enables. From these it picks the winning interrupt, chooses between supervisor entry, machine entry, debug entry and a debug-mode redirect, and produces every value the core commits for that trap.

One clock edge after a request, the outputs present the new PC, the new privilege, write strobes for the supervisor or machine trap registers, the cause, the saved PC and the faulting address. They also present the updated status bits and, for debug entry, the debug cause, the saved privilege and the debug PC. A one-cycle pulse tells the memory side to drop any load reservation. Executing instructions and decoding CSR accesses are left to the surrounding core.

Top module: `trap_entry_ctrl`

## Requirements
- R1: While reset is asserted the outputs hold the idle state: o_valid, every write strobe, o_resv_cancel and o_dbg_enter are 0, o_pc is 0 and o_prv is 3 (machine). Privilege encoding is U=0, S=1, H=2, M=3.
- R2: When i_irq_sample is high, machine candidates are i_irq_pending & ~i_mideleg. They are enabled when the folded privilege is below 3, or is 3 with i_mie set.
- R3: Supervisor candidates (i_irq_pending & i_mideleg) are considered only when no enabled machine candidate exists. They are enabled when the folded privilege is 0, or is 1 with i_sie set.
- R4: Among the enabled candidates the lowest-numbered set bit wins, and the cause is 0x8000_0000 plus that bit number. A taken interrupt has priority over an exception presented in the same cycle.
- R5: A trap goes to supervisor mode only when the folded privilege is 0 or 1 and the delegation bit is set. For an exception that bit is i_medeleg[code], and a code of 32 or more never delegates. For an interrupt it is i_mideleg[index]. Every other trap goes to machine mode.
- R6: On supervisor entry: o_pc = i_stvec, o_prv = 1, o_wr_s = 1, o_cause and o_epc (= i_pc) are written, o_spie = old i_sie, o_spp = bit 0 of the folded privilege and o_sie = 0. The machine status bits pass through unchanged.
- R7: On machine entry: o_prv = 3 and o_wr_m = 1. o_pc = i_mtvec with bit 0 cleared, plus 4 × index when i_mtvec[0] is set and the trap is an interrupt. o_mpie = old i_mie, o_mpp = folded privilege and o_mie = 0. The supervisor status bits pass through unchanged.
- R8: o_badaddr_we is 1 and o_badaddr = i_exc_addr only for an exception with i_exc_has_addr set that enters S or M. Otherwise both are 0.
- R9: An exception with code 3 (breakpoint) while i_ebreak_en[folded privilege] is set enters debug mode. The results are o_dbg_enter = 1, o_dbg_cause = 1, o_dbg_prv = folded privilege, o_dpc = i_pc, o_pc = DBG_ROM_BASE (0x800) and o_prv = 3. There is no S/M register write and the status bits are unchanged.
- R10: While i_in_debug is high any trap only sets o_valid and o_pc = DBG_ROM_EXC (0x808). o_prv stays at the folded privilege and there are no writes or status changes.
- R11: An incoming privilege of 2 (H) is folded to 0 (U) for every decision and every saved privilege.
- R12: o_resv_cancel is a pulse exactly in the output cycle of an S or M entry.
- R13: With neither i_exc_valid nor i_irq_sample high, o_valid is 0 in the next cycle, whatever interrupts are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_exc_valid | input | 1 | Exception request this cycle |
| i_exc_code | input | CODE_W | Exception code |
| i_exc_has_addr | input | 1 | Exception carries a faulting address |
| i_exc_addr | input | XLEN | Faulting address |
| i_pc | input | XLEN | PC of the trapping or interrupted instruction |
| i_irq_sample | input | 1 | Instruction boundary where interrupts may be taken |
| i_irq_pending | input | XLEN | Pending interrupt vector |
| i_prv | input | 2 | Current privilege |
| i_sie | input | 1 | Supervisor interrupt enable |
| i_spie | input | 1 | Supervisor previous enable |
| i_spp | input | 1 | Supervisor previous privilege |
| i_mie | input | 1 | Machine interrupt enable |
| i_mpie | input | 1 | Machine previous enable |
| i_mpp | input | 2 | Machine previous privilege |
| i_medeleg | input | XLEN | Exception delegation mask |
| i_mideleg | input | XLEN | Interrupt delegation mask |
| i_mtvec | input | XLEN | Machine trap vector, bit 0 selects vectored interrupts |
| i_stvec | input | XLEN | Supervisor trap vector |
| i_ebreak_en | input | 4 | Breakpoint-to-debug enable, indexed by privilege |
| i_in_debug | input | 1 | A debug cause is recorded |
| o_valid | output | 1 | A trap result is presented |
| o_pc | output | XLEN | Next PC |
| o_prv | output | 2 | Next privilege |
| o_wr_s | output | 1 | Write supervisor trap registers |
| o_wr_m | output | 1 | Write machine trap registers |
| o_cause | output | XLEN | Cause value |
| o_epc | output | XLEN | Saved PC |
| o_badaddr_we | output | 1 | Write the bad-address register |
| o_badaddr | output | XLEN | Bad-address value |
| o_sie | output | 1 | Updated supervisor enable |
| o_spie | output | 1 | Updated supervisor previous enable |
| o_spp | output | 1 | Updated supervisor previous privilege |
| o_mie | output | 1 | Updated machine enable |
| o_mpie | output | 1 | Updated machine previous enable |
| o_mpp | output | 2 | Updated machine previous privilege |
| o_dbg_enter | output | 1 | Debug mode entered |
| o_dbg_cause | output | 3 | Debug cause code |
| o_dbg_prv | output | 2 | Privilege saved on debug entry |
| o_dpc | output | XLEN | Debug PC |
| o_resv_cancel | output | 1 | Drop load reservation pulse |

## Verification
The bench sweeps every privilege, both enable bits and several pending and delegation patterns, so a design that scans from the top bit, or that lets supervisor candidates compete while a machine candidate waits, reports the wrong cause. Exception codes run past 31 against an all-ones delegation mask; a design that truncates the code would wrongly delegate codes 32 to 39. Privilege 2 appears in every sweep, and an unfolded value would show up in the saved privilege fields and the delegation choice. The breakpoint sweep covers all 16 enable patterns, with and without i_in_debug, so a design that indexes the enables by the raw privilege, or lets a breakpoint escape the debug redirect, is caught.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [1:0] {
        PRV_U = 2'd0,
        PRV_S = 2'd1,
        PRV_H = 2'd2,
        PRV_M = 2'd3
    } prv_e;

    typedef enum logic [2:0] {
        RT_NONE      = 3'd0,
        RT_DBG_EXC   = 3'd1,
        RT_DBG_ENTER = 3'd2,
        RT_TO_S      = 3'd3,
        RT_TO_M      = 3'd4
    } route_e;

    localparam logic [2:0] DBG_CAUSE_SWBP = 3'd1;

    // The hypervisor level is never a target; it collapses to user.
    function automatic logic [1:0] prv_fold(input logic [1:0] p);
        return (p == PRV_H) ? PRV_U : p;
    endfunction

endpackage

// File: rtl/trap_irq_pick.sv
module trap_irq_pick #(
    parameter int XLEN  = 32,
    parameter int IDX_W = $clog2(XLEN)
) (
    input  logic [XLEN-1:0]  pend,
    input  logic [XLEN-1:0]  mid,
    input  logic [1:0]       prv,
    input  logic             mie,
    input  logic             sie,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    import trap_pkg::*;

    localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};

    function automatic logic [XLEN-1:0] idx_mask(input int b);
        logic [XLEN-1:0] m;
        m = '0;
        for (int i = 0; i < XLEN; i++) begin
            if (((i >> b) & 1) == 1) m[i] = 1'b1;
        end
        return m;
    endfunction

    logic            m_en;
    logic            s_en;
    logic [XLEN-1:0] m_cand;
    logic [XLEN-1:0] s_cand;
    logic [XLEN-1:0] win;
    logic [XLEN-1:0] lowest;

    always_comb begin
        m_en   = (prv != PRV_M) || mie;
        s_en   = (prv == PRV_U) || ((prv == PRV_S) && sie);
        m_cand = m_en ? (pend & ~mid) : '0;
        s_cand = s_en ? (pend & mid) : '0;
        win    = (m_cand != '0) ? m_cand : s_cand;
        lowest = win & (~win + ONE);
        hit    = (win != '0);
    end

    for (genvar b = 0; b < IDX_W; b++) begin : g_enc
        assign idx[b] = |(lowest & idx_mask(b));
    end

endmodule

// File: rtl/trap_route.sv
module trap_route #(
    parameter int XLEN     = 32,
    parameter int CODE_W   = 6,
    parameter int IDX_W    = $clog2(XLEN),
    parameter int BRK_CODE = 3
) (
    input  logic              req_exc,
    input  logic              req_irq,
    input  logic [CODE_W-1:0] code,
    input  logic [IDX_W-1:0]  irq_idx,
    input  logic [1:0]        prv,
    input  logic [XLEN-1:0]   medeleg,
    input  logic [XLEN-1:0]   mideleg,
    input  logic [3:0]        ebreak_en,
    input  logic              in_debug,
    output trap_pkg::route_e  route
);
    import trap_pkg::*;

    logic code_fits;
    logic exc_del;
    logic irq_del;
    logic low_prv;
    logic brk_hit;
    logic del;

    always_comb begin
        code_fits = (int'(code) < XLEN);
        exc_del   = code_fits && medeleg[code[IDX_W-1:0]];
        irq_del   = mideleg[irq_idx];
        low_prv   = (prv == PRV_U) || (prv == PRV_S);
        brk_hit   = !req_irq && (code == CODE_W'(BRK_CODE)) && ebreak_en[prv];
        del       = low_prv && (req_irq ? irq_del : exc_del);

        if (!(req_irq || req_exc)) begin
            route = RT_NONE;
        end else if (in_debug) begin
            route = RT_DBG_EXC;
        end else if (brk_hit) begin
            route = RT_DBG_ENTER;
        end else if (del) begin
            route = RT_TO_S;
        end else begin
            route = RT_TO_M;
        end
    end

endmodule

// File: rtl/trap_vec_calc.sv
module trap_vec_calc #(
    parameter int              XLEN         = 32,
    parameter int              IDX_W        = $clog2(XLEN),
    parameter logic [XLEN-1:0] DBG_ROM_BASE = 32'h0000_0800,
    parameter logic [XLEN-1:0] DBG_ROM_EXC  = 32'h0000_0808
) (
    input  trap_pkg::route_e route,
    input  logic             is_irq,
    input  logic [IDX_W-1:0] idx,
    input  logic [XLEN-1:0]  mtvec,
    input  logic [XLEN-1:0]  stvec,
    output logic [XLEN-1:0]  pc
);
    import trap_pkg::*;

    logic [XLEN-1:0] m_base;
    logic [XLEN-1:0] m_off;

    always_comb begin
        m_base = {mtvec[XLEN-1:1], 1'b0};
        m_off  = (mtvec[0] && is_irq) ? {{(XLEN-IDX_W-2){1'b0}}, idx, 2'b00} : '0;
        case (route)
            RT_TO_S:      pc = stvec;
            RT_TO_M:      pc = m_base + m_off;
            RT_DBG_ENTER: pc = DBG_ROM_BASE;
            RT_DBG_EXC:   pc = DBG_ROM_EXC;
            default:      pc = '0;
        endcase
    end

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl #(
    parameter int              XLEN         = 32,
    parameter int              CODE_W       = 6,
    parameter int              BRK_CODE     = 3,
    parameter logic [XLEN-1:0] DBG_ROM_BASE = 32'h0000_0800,
    parameter logic [XLEN-1:0] DBG_ROM_EXC  = 32'h0000_0808
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i_exc_valid,
    input  logic [CODE_W-1:0] i_exc_code,
    input  logic              i_exc_has_addr,
    input  logic [XLEN-1:0]   i_exc_addr,
    input  logic [XLEN-1:0]   i_pc,
    input  logic              i_irq_sample,
    input  logic [XLEN-1:0]   i_irq_pending,
    input  logic [1:0]        i_prv,
    input  logic              i_sie,
    input  logic              i_spie,
    input  logic              i_spp,
    input  logic              i_mie,
    input  logic              i_mpie,
    input  logic [1:0]        i_mpp,
    input  logic [XLEN-1:0]   i_medeleg,
    input  logic [XLEN-1:0]   i_mideleg,
    input  logic [XLEN-1:0]   i_mtvec,
    input  logic [XLEN-1:0]   i_stvec,
    input  logic [3:0]        i_ebreak_en,
    input  logic              i_in_debug,
    output logic              o_valid,
    output logic [XLEN-1:0]   o_pc,
    output logic [1:0]        o_prv,
    output logic              o_wr_s,
    output logic              o_wr_m,
    output logic [XLEN-1:0]   o_cause,
    output logic [XLEN-1:0]   o_epc,
    output logic              o_badaddr_we,
    output logic [XLEN-1:0]   o_badaddr,
    output logic              o_sie,
    output logic              o_spie,
    output logic              o_spp,
    output logic              o_mie,
    output logic              o_mpie,
    output logic [1:0]        o_mpp,
    output logic              o_dbg_enter,
    output logic [2:0]        o_dbg_cause,
    output logic [1:0]        o_dbg_prv,
    output logic [XLEN-1:0]   o_dpc,
    output logic              o_resv_cancel
);
    import trap_pkg::*;

    localparam int IDX_W = $clog2(XLEN);

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] pc;
        logic [1:0]      prv;
        logic            wr_s;
        logic            wr_m;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] epc;
        logic            baddr_we;
        logic [XLEN-1:0] baddr;
        logic            sie;
        logic            spie;
        logic            spp;
        logic            mie;
        logic            mpie;
        logic [1:0]      mpp;
        logic            dbg_enter;
        logic [2:0]      dbg_cause;
        logic [1:0]      dbg_prv;
        logic [XLEN-1:0] dpc;
        logic            resv;
    } trap_out_s;

    trap_out_s out_d, out_q;

    logic [1:0]       prv_n;
    logic             irq_hit;
    logic [IDX_W-1:0] irq_idx;
    logic             take_irq;
    route_e           route;
    logic [XLEN-1:0]  pc_n;
    logic [XLEN-1:0]  cause_n;

    assign prv_n    = prv_fold(i_prv);
    assign take_irq = i_irq_sample && irq_hit;

    trap_irq_pick #(.XLEN(XLEN), .IDX_W(IDX_W)) u_pick (
        .pend (i_irq_pending),
        .mid  (i_mideleg),
        .prv  (prv_n),
        .mie  (i_mie),
        .sie  (i_sie),
        .hit  (irq_hit),
        .idx  (irq_idx)
    );

    trap_route #(.XLEN(XLEN), .CODE_W(CODE_W), .IDX_W(IDX_W), .BRK_CODE(BRK_CODE)) u_route (
        .req_exc   (i_exc_valid),
        .req_irq   (take_irq),
        .code      (i_exc_code),
        .irq_idx   (irq_idx),
        .prv       (prv_n),
        .medeleg   (i_medeleg),
        .mideleg   (i_mideleg),
        .ebreak_en (i_ebreak_en),
        .in_debug  (i_in_debug),
        .route     (route)
    );

    trap_vec_calc #(
        .XLEN(XLEN), .IDX_W(IDX_W),
        .DBG_ROM_BASE(DBG_ROM_BASE), .DBG_ROM_EXC(DBG_ROM_EXC)
    ) u_vec (
        .route  (route),
        .is_irq (take_irq),
        .idx    (irq_idx),
        .mtvec  (i_mtvec),
        .stvec  (i_stvec),
        .pc     (pc_n)
    );

    assign cause_n = take_irq ? {1'b1, {(XLEN-1-IDX_W){1'b0}}, irq_idx}
                              : {{(XLEN-CODE_W){1'b0}}, i_exc_code};

    always_comb begin
        out_d      = '0;
        out_d.prv  = prv_n;
        out_d.sie  = i_sie;
        out_d.spie = i_spie;
        out_d.spp  = i_spp;
        out_d.mie  = i_mie;
        out_d.mpie = i_mpie;
        out_d.mpp  = i_mpp;
        out_d.pc   = pc_n;

        case (route)
            RT_DBG_EXC: begin
                out_d.valid = 1'b1;
            end
            RT_DBG_ENTER: begin
                out_d.valid     = 1'b1;
                out_d.prv       = PRV_M;
                out_d.dbg_enter = 1'b1;
                out_d.dbg_cause = DBG_CAUSE_SWBP;
                out_d.dbg_prv   = prv_n;
                out_d.dpc       = i_pc;
            end
            RT_TO_S, RT_TO_M: begin
                out_d.valid    = 1'b1;
                out_d.cause    = cause_n;
                out_d.epc      = i_pc;
                out_d.baddr_we = i_exc_has_addr && !take_irq;
                out_d.baddr    = (i_exc_has_addr && !take_irq) ? i_exc_addr : '0;
                out_d.resv     = 1'b1;
                if (route == RT_TO_S) begin
                    out_d.wr_s = 1'b1;
                    out_d.prv  = PRV_S;
                    out_d.spie = i_sie;
                    out_d.spp  = prv_n[0];
                    out_d.sie  = 1'b0;
                end else begin
                    out_d.wr_m = 1'b1;
                    out_d.prv  = PRV_M;
                    out_d.mpie = i_mie;
                    out_d.mpp  = prv_n;
                    out_d.mie  = 1'b0;
                end
            end
            default: begin
                out_d.pc = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q     <= '0;
            out_q.prv <= PRV_M;
        end else begin
            out_q     <= out_d;
        end
    end

    assign o_valid       = out_q.valid;
    assign o_pc          = out_q.pc;
    assign o_prv         = out_q.prv;
    assign o_wr_s        = out_q.wr_s;
    assign o_wr_m        = out_q.wr_m;
    assign o_cause       = out_q.cause;
    assign o_epc         = out_q.epc;
    assign o_badaddr_we  = out_q.baddr_we;
    assign o_badaddr     = out_q.baddr;
    assign o_sie         = out_q.sie;
    assign o_spie        = out_q.spie;
    assign o_spp         = out_q.spp;
    assign o_mie         = out_q.mie;
    assign o_mpie        = out_q.mpie;
    assign o_mpp         = out_q.mpp;
    assign o_dbg_enter   = out_q.dbg_enter;
    assign o_dbg_cause   = out_q.dbg_cause;
    assign o_dbg_prv     = out_q.dbg_prv;
    assign o_dpc         = out_q.dpc;
    assign o_resv_cancel = out_q.resv;

endmodule

// File: rtl/trap_entry_ctrl_chk.sv
module trap_entry_ctrl_chk #(
    parameter int              XLEN         = 32,
    parameter logic [XLEN-1:0] DBG_ROM_BASE = 32'h0000_0800,
    parameter logic [XLEN-1:0] DBG_ROM_EXC  = 32'h0000_0808
) (
    input logic            clk,
    input logic            rst_n,
    input logic            i_exc_valid,
    input logic            i_irq_sample,
    input logic            i_in_debug,
    input logic [1:0]      i_prv,
    input logic            o_valid,
    input logic [XLEN-1:0] o_pc,
    input logic [1:0]      o_prv,
    input logic            o_wr_s,
    input logic            o_wr_m,
    input logic            o_cause_msb,
    input logic            o_badaddr_we,
    input logic            o_sie,
    input logic            o_mie,
    input logic            o_dbg_enter,
    input logic [2:0]      o_dbg_cause,
    input logic            o_resv_cancel
);

    AST_IDLE_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!i_exc_valid && !i_irq_sample) |=> !o_valid);                       // R13

    AST_DEBUG_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (i_in_debug && i_exc_valid) |=>
        (o_valid && o_pc == DBG_ROM_EXC && !o_wr_s && !o_wr_m && !o_dbg_enter)); // R10

    AST_M_NEVER_DELEG: assert property (@(posedge clk) disable iff (!rst_n)
        (i_exc_valid && !i_irq_sample && !i_in_debug && i_prv == 2'd3) |=> !o_wr_s); // R5

    AST_S_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        o_wr_s |-> (o_prv == 2'd1 && !o_sie && !o_wr_m));                    // R6

    AST_M_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        o_wr_m |-> (o_prv == 2'd3 && !o_mie));                               // R7

    AST_BADADDR_EXC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        o_badaddr_we |-> ((o_wr_s || o_wr_m) && !o_cause_msb));              // R8

    AST_DBG_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        o_dbg_enter |-> (o_prv == 2'd3 && o_pc == DBG_ROM_BASE && o_dbg_cause == 3'd1)); // R9

    AST_RESV_WITH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        o_resv_cancel |-> (o_wr_s || o_wr_m));                               // R12

    AST_RESV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (o_resv_cancel && !i_exc_valid && !i_irq_sample) |=> !o_resv_cancel); // R12

endmodule

bind trap_entry_ctrl trap_entry_ctrl_chk #(
    .XLEN(XLEN), .DBG_ROM_BASE(DBG_ROM_BASE), .DBG_ROM_EXC(DBG_ROM_EXC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .i_exc_valid   (i_exc_valid),
    .i_irq_sample  (i_irq_sample),
    .i_in_debug    (i_in_debug),
    .i_prv         (i_prv),
    .o_valid       (o_valid),
    .o_pc          (o_pc),
    .o_prv         (o_prv),
    .o_wr_s        (o_wr_s),
    .o_wr_m        (o_wr_m),
    .o_cause_msb   (o_cause[XLEN-1]),
    .o_badaddr_we  (o_badaddr_we),
    .o_sie         (o_sie),
    .o_mie         (o_mie),
    .o_dbg_enter   (o_dbg_enter),
    .o_dbg_cause   (o_dbg_cause),
    .o_resv_cancel (o_resv_cancel)
);

// File: tb/trap_entry_ctrl_bench.sv
`timescale 1ns/1ps
module trap_entry_ctrl_bench;
    localparam int XLEN = 32;
    localparam int CODE_W = 6;
    localparam logic [31:0] DBASE = 32'h0000_0800;
    localparam logic [31:0] DEXC  = 32'h0000_0808;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic i_exc_valid = 0, i_exc_has_addr = 0, i_irq_sample = 0, i_in_debug = 0;
    logic [CODE_W-1:0] i_exc_code = '0;
    logic [31:0] i_exc_addr = '0, i_pc = '0, i_irq_pending = '0;
    logic [1:0] i_prv = 2'd3, i_mpp = 2'd0;
    logic i_sie = 0, i_spie = 0, i_spp = 0, i_mie = 0, i_mpie = 0;
    logic [31:0] i_medeleg = '0, i_mideleg = '0, i_mtvec = '0, i_stvec = '0;
    logic [3:0] i_ebreak_en = '0;

    logic o_valid, o_wr_s, o_wr_m, o_badaddr_we, o_sie, o_spie, o_spp, o_mie, o_mpie;
    logic o_dbg_enter, o_resv_cancel;
    logic [31:0] o_pc, o_cause, o_epc, o_badaddr, o_dpc;
    logic [1:0] o_prv, o_mpp, o_dbg_prv;
    logic [2:0] o_dbg_cause;

    always #2.5 clk = ~clk;

    trap_entry_ctrl u_trap_entry_ctrl (.*);

    int n_chk = 0;
    int n_bad = 0;

    // expected values
    logic e_valid, e_wr_s, e_wr_m, e_bwe, e_dbg, e_resv;
    logic [31:0] e_pc, e_cause, e_epc, e_baddr, e_dpc;
    logic [1:0] e_prv, e_dprv;
    logic [2:0] e_dcause;
    logic [7:0] e_stat;
    string t_en, t_rt;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model();
        logic [1:0] np;
        logic me, se, irq, del;
        logic [31:0] mc, sc, en;
        int idx;
        np = (i_prv == 2'd2) ? 2'd0 : i_prv;
        e_valid = 0; e_wr_s = 0; e_wr_m = 0; e_bwe = 0; e_dbg = 0; e_resv = 0;
        e_pc = 0; e_cause = 0; e_epc = 0; e_baddr = 0; e_dpc = 0;
        e_prv = np; e_dprv = 0; e_dcause = 0;
        e_stat = {i_sie, i_spie, i_spp, i_mie, i_mpie, i_mpp, 1'b0};
        t_en = "R13"; t_rt = "R13";
        irq = 0; idx = 0;
        if (i_irq_sample) begin
            me = (np != 2'd3) || i_mie;
            se = (np == 2'd0) || (np == 2'd1 && i_sie);
            mc = me ? (i_irq_pending & ~i_mideleg) : 32'h0;
            sc = se ? (i_irq_pending & i_mideleg) : 32'h0;
            en = (mc != 0) ? mc : sc;
            t_en = (mc != 0) ? "R2" : "R3";
            for (int i = XLEN - 1; i >= 0; i--) if (en[i]) idx = i;
            irq = (en != 0);
        end
        if (!(irq || i_exc_valid)) return;
        e_valid = 1;
        if (i_in_debug) begin
            e_pc = DEXC; t_rt = "R10"; return;
        end
        if (!irq && i_exc_code == 6'd3 && i_ebreak_en[np]) begin
            e_pc = DBASE; e_prv = 2'd3; e_dbg = 1; e_dcause = 3'd1;
            e_dprv = np; e_dpc = i_pc; t_rt = "R9"; return;
        end
        e_cause = irq ? (32'h8000_0000 + idx) : {26'h0, i_exc_code};
        if (irq) del = (np <= 2'd1) && i_mideleg[idx];
        else del = (np <= 2'd1) && (i_exc_code < 6'd32) && i_medeleg[i_exc_code[4:0]];
        e_epc = i_pc;
        e_bwe = !irq && i_exc_has_addr;
        e_baddr = e_bwe ? i_exc_addr : 32'h0;
        e_resv = 1;
        if (del) begin
            e_pc = i_stvec; e_prv = 2'd1; e_wr_s = 1; t_rt = "R6";
            e_stat = {1'b0, i_sie, np[0], i_mie, i_mpie, i_mpp, 1'b0};
        end else begin
            e_pc = {i_mtvec[31:1], 1'b0} + ((i_mtvec[0] && irq) ? idx * 4 : 0);
            e_prv = 2'd3; e_wr_m = 1; t_rt = "R7";
            e_stat = {i_sie, i_spie, i_spp, 1'b0, i_mie, np, 1'b0};
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        model();
        chk({t_en, "/", t_rt, " valid"}, 32'(o_valid), 32'(e_valid));
        chk({t_rt, " pc"}, o_pc, e_pc);
        chk({(i_prv == 2'd2) ? "R11" : t_rt, " prv"}, 32'(o_prv), 32'(e_prv));
        chk("R5 route", {30'h0, o_wr_s, o_wr_m}, {30'h0, e_wr_s, e_wr_m});
        chk({(e_cause[31] ? "R4" : t_rt), " cause"}, o_cause, e_cause);
        chk({t_rt, " epc"}, o_epc, e_epc);
        chk("R8 badaddr", {o_badaddr[31:1], o_badaddr[0] ^ o_badaddr_we},
            {e_baddr[31:1], e_baddr[0] ^ e_bwe});
        chk("R8 badaddr_we", 32'(o_badaddr_we), 32'(e_bwe));
        chk({(i_prv == 2'd2) ? "R11" : t_rt, " status"},
            32'({o_sie, o_spie, o_spp, o_mie, o_mpie, o_mpp, 1'b0}), 32'(e_stat));
        chk("R9 debug", {24'h0, o_dbg_enter, o_dbg_cause, o_dbg_prv, 2'b00},
            {24'h0, e_dbg, e_dcause, e_dprv, 2'b00});
        chk("R9 dpc", o_dpc, e_dpc);
        chk("R12 resv", 32'(o_resv_cancel), 32'(e_resv));
    endtask

    initial begin
        #750000;
        n_bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] pend_tab [8];
        logic [31:0] mid_tab [4];
        pend_tab = '{32'h0, 32'h2, 32'h20, 32'h22, 32'h880, 32'h8000_0200, 32'hFFFF_FFFF, 32'h0001_0008};
        mid_tab  = '{32'h0, 32'h222, 32'hFFFF_FFFF, 32'h8};

        // R1: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 valid", 32'(o_valid), 0);
        chk("R1 prv", 32'(o_prv), 3);
        chk("R1 pc", o_pc, 0);
        chk("R1 strobes", {27'h0, o_wr_s, o_wr_m, o_dbg_enter, o_resv_cancel, o_badaddr_we}, 0);
        rst_n = 1'b1;

        // R13: nothing requested while interrupts pend and are enabled
        i_irq_pending = 32'hFFFF_FFFF; i_mie = 1; i_prv = 2'd0;
        for (int k = 0; k < 4; k++) begin
            i_pc = 32'h40 + k * 4;
            step();
        end

        // R2 R3 R4 R6 R7 R11: interrupt sweep, with and without a competing exception
        i_stvec = 32'h0000_2000;
        i_exc_code = 6'd5; i_exc_addr = 32'hDEAD_0000; i_exc_has_addr = 1;
        for (int p = 0; p < 4; p++)
            for (int ie = 0; ie < 4; ie++)
                for (int d = 0; d < 4; d++)
                    for (int q = 0; q < 8; q++)
                        for (int v = 0; v < 4; v++) begin
                            @(negedge clk);
                            i_prv = 2'(p);
                            i_mie = ie[0]; i_sie = ie[1];
                            i_spie = ~ie[0]; i_spp = ie[1]; i_mpie = ie[1]; i_mpp = 2'(q);
                            i_mideleg = mid_tab[d];
                            i_irq_pending = pend_tab[q];
                            i_mtvec = {28'h0000_400, 3'b000, v[0]};
                            i_exc_valid = v[1];
                            i_irq_sample = 1'b1;
                            i_pc = 32'h1000 + q * 8 + v;
                            step();
                        end

        // R5 R6 R7 R8 R11: exception sweep including codes beyond the register width
        i_irq_sample = 0; i_exc_valid = 1; i_mtvec = 32'h0000_4001;
        for (int c = 0; c < 40; c++)
            for (int p = 0; p < 4; p++)
                for (int m = 0; m < 2; m++)
                    for (int a = 0; a < 2; a++) begin
                        @(negedge clk);
                        i_exc_code = 6'(c); i_prv = 2'(p);
                        i_medeleg = m[0] ? 32'hFFFF_FFFF : 32'hAAAA_5555;
                        i_exc_has_addr = a[0];
                        i_exc_addr = 32'hBAD0_0000 + c;
                        i_sie = c[0]; i_mie = c[1]; i_spie = c[2]; i_mpie = ~c[2];
                        i_spp = c[3]; i_mpp = 2'(c >> 1);
                        i_pc = 32'h2000 + c * 4;
                        step();
                    end

        // R9 R10 R11: breakpoint enables per privilege, and redirect while in debug
        i_medeleg = 32'hFFFF_FFFF;
        for (int e = 0; e < 16; e++)
            for (int p = 0; p < 4; p++)
                for (int dbg = 0; dbg < 2; dbg++) begin
                    @(negedge clk);
                    i_ebreak_en = 4'(e); i_prv = 2'(p); i_in_debug = dbg[0];
                    i_exc_code = 6'd3; i_exc_has_addr = 1;
                    i_pc = 32'h3000 + e * 16 + p * 4;
                    step();
                end

        // R10: interrupt while in debug
        @(negedge clk);
        i_in_debug = 1; i_exc_valid = 0; i_irq_sample = 1;
        i_irq_pending = 32'h80; i_mideleg = 0; i_prv = 2'd0;
        step();

        // R12: pulse drops once requests stop
        @(negedge clk);
        i_in_debug = 0; i_irq_sample = 0; i_exc_valid = 1; i_exc_code = 6'd2;
        step();
        @(negedge clk);
        i_exc_valid = 0;
        step();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule